// File: doc/BRIEF.md
# Resumable NMI Trap-State Register Unit

This unit keeps the state a 32-bit RISC-V-style hart needs to come back from a non-maskable interrupt. It has its own copy of that state, separate from the normal machine trap registers. An NMI that arrives while a machine trap handler is running therefore leaves the handler's own exception PC and cause untouched. The unit holds four words, each reachable through a CSR port with a 12-bit address:

- a scratch word,
- a return PC,
- a cause word,
- a status word with an NMI-enable bit and a previous-privilege field.

The hart pulses an entry strobe when it takes an NMI, and passes in the interrupted PC, the cause and the current privilege. The hart also presents each issued instruction word. The unit recognises the NMI-return instruction, flags it as illegal outside machine mode, and otherwise hands back the PC and privilege to resume at. It also signals whether the modify-privilege bit of the machine status must be cleared.

Top module: `nmi_resume_regs`

## Requirements
- R1: After reset, reads of addresses 0x740, 0x741, 0x742 and 0x744 all return zero, and no return is signalled.
- R2: On an entry strobe, the supplied PC is stored in the return-PC word (address 0x741). An accepted return drives that stored value on `ret_pc`.
- R3: The cause word (address 0x742) keeps only bit 31 (interrupt flag) and bits 5:0 (cause code); bits 30:6 read as zero. This holds for software writes and for entry capture.
- R4: In the status word (address 0x744), bit 3 is NMI-enable and bits 12:11 are previous privilege; all other bits read zero. Entry clears NMI-enable, and `nmi_enable` reflects its value.
- R5: A software write to the previous-privilege field stores 2'b00 as user and 2'b11 as machine; the values 2'b01 and 2'b10 are stored as machine (2'b11).
- R6: On entry, the current privilege is recorded in the previous-privilege field.
- R7: The return instruction is the exact word 32'h70200073 (funct12 0x702, system opcode 7'h73). If it is issued with `cur_priv` not equal to 2'b11, `illegal_insn` is high and `ret_valid` is low. Any other word raises neither output.
- R8: A software write to the return-PC word stores bit 0 as zero.
- R9: On an accepted return, `ret_priv` equals the previous-privilege field. `clear_mprv` is high exactly when that field is not 2'b11.
- R10: An accepted return sets NMI-enable to 1 on the following clock edge.
- R11: When an entry strobe and a CSR write land in the same cycle, the entry values win in the return-PC, cause and status words.
- R12: The scratch word (address 0x740) is a plain 32-bit read/write word. Reads of any other unimplemented address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_we | input | 1 | CSR write enable |
| csr_rdata | output | 32 | CSR read data (combinational) |
| nmi_take | input | 1 | NMI entry strobe |
| nmi_pc | input | 32 | PC of the interrupted instruction |
| nmi_is_irq | input | 1 | Trap came from an interrupt |
| nmi_code | input | 6 | NMI cause code |
| cur_priv | input | 2 | Current privilege level |
| insn_valid | input | 1 | Instruction word is issued this cycle |
| insn | input | 32 | Issued instruction word |
| ret_valid | output | 1 | Accepted NMI return this cycle |
| ret_pc | output | 32 | PC to resume at |
| ret_priv | output | 2 | Privilege to resume in |
| clear_mprv | output | 1 | Clear machine modify-privilege bit |
| illegal_insn | output | 1 | Return issued outside machine mode |
| nmi_enable | output | 1 | Current NMI-enable bit |

## Verification
The bench writes the reserved privilege codes 2'b01 and 2'b10 and expects machine mode back. A unit that stored them raw would later return into a privilege the hart cannot run. It issues the return from user mode, where a faulty unit would resume instead of trapping. It also issues the return after an entry from user mode, where a unit that failed to request clearing modify-privilege would leave user code with machine-level data access. Same-cycle entry plus CSR write targets the priority rule: a wrong order would lose the interrupted PC or leave NMIs unmasked. The odd-PC write and the all-ones cause write target field masking.

// File: rtl/nmi_resume_regs.sv
module nmi_resume_regs #(
  parameter int XLEN = 32,
  parameter int CODE_W = 6,
  parameter logic [11:0] ADDR_SCRATCH = 12'h740,
  parameter logic [11:0] ADDR_EPC = 12'h741,
  parameter logic [11:0] ADDR_CAUSE = 12'h742,
  parameter logic [11:0] ADDR_STATUS = 12'h744,
  parameter logic [31:0] RET_INSN = 32'h7020_0073,
  parameter int EN_BIT = 3,
  parameter int PP_LO = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            nmi_take,
  input  logic [XLEN-1:0] nmi_pc,
  input  logic            nmi_is_irq,
  input  logic [CODE_W-1:0] nmi_code,
  input  logic [1:0]      cur_priv,
  input  logic            insn_valid,
  input  logic [31:0]     insn,
  output logic            ret_valid,
  output logic [XLEN-1:0] ret_pc,
  output logic [1:0]      ret_priv,
  output logic            clear_mprv,
  output logic            illegal_insn,
  output logic            nmi_enable
);
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] PRIV_U = 2'b00;

  logic [XLEN-1:0]   scratch_q, epc_q;
  logic              irq_q;
  logic [CODE_W-1:0] code_q;
  logic              en_q;
  logic [1:0]        pp_q;

  logic ret_hit, ret_fire;
  logic wr_scratch, wr_epc, wr_cause, wr_status;
  logic [1:0] wr_pp, take_pp;

  assign ret_hit  = insn_valid && (insn == RET_INSN);
  assign ret_fire = ret_hit && (cur_priv == PRIV_M);

  assign wr_scratch = csr_we && (csr_addr == ADDR_SCRATCH);
  assign wr_epc     = csr_we && (csr_addr == ADDR_EPC);
  assign wr_cause   = csr_we && (csr_addr == ADDR_CAUSE);
  assign wr_status  = csr_we && (csr_addr == ADDR_STATUS);

  assign wr_pp   = (csr_wdata[PP_LO+1:PP_LO] == PRIV_U) ? PRIV_U : PRIV_M;
  assign take_pp = (cur_priv == PRIV_U) ? PRIV_U : PRIV_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      epc_q     <= '0;
      irq_q     <= 1'b0;
      code_q    <= '0;
      en_q      <= 1'b0;
      pp_q      <= PRIV_U;
    end else begin
      if (wr_scratch) scratch_q <= csr_wdata;

      if (nmi_take) begin
        epc_q  <= nmi_pc;
        irq_q  <= nmi_is_irq;
        code_q <= nmi_code;
        pp_q   <= take_pp;
        en_q   <= 1'b0;
      end else begin
        if (wr_epc) epc_q <= {csr_wdata[XLEN-1:1], 1'b0};
        if (wr_cause) begin
          irq_q  <= csr_wdata[XLEN-1];
          code_q <= csr_wdata[CODE_W-1:0];
        end
        if (wr_status) pp_q <= wr_pp;
        if (ret_fire) en_q <= 1'b1;
        else if (wr_status) en_q <= csr_wdata[EN_BIT];
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (csr_addr)
      ADDR_SCRATCH: csr_rdata = scratch_q;
      ADDR_EPC:     csr_rdata = epc_q;
      ADDR_CAUSE: begin
        csr_rdata[XLEN-1]     = irq_q;
        csr_rdata[CODE_W-1:0] = code_q;
      end
      ADDR_STATUS: begin
        csr_rdata[EN_BIT]        = en_q;
        csr_rdata[PP_LO+1:PP_LO] = pp_q;
      end
      default: csr_rdata = '0;
    endcase
  end

  assign ret_valid    = ret_fire;
  assign ret_pc       = epc_q;
  assign ret_priv     = pp_q;
  assign clear_mprv   = ret_fire && (pp_q != PRIV_M);
  assign illegal_insn = ret_hit && (cur_priv != PRIV_M);
  assign nmi_enable   = en_q;

  a_r2_entry_pc: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> (epc_q == $past(nmi_pc)));

  a_r4_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> !nmi_enable);

  a_r10_return_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !nmi_take) |=> nmi_enable);

  a_r7_no_return_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_insn |-> !ret_valid);

  a_r5_pp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_priv == PRIV_M) || (ret_priv == PRIV_U));

  a_r8_epc_even: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == ADDR_EPC && !nmi_take) |=> !ret_pc[0]);

  a_r11_entry_wins_status: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_take && csr_we && csr_addr == ADDR_STATUS) |=> !nmi_enable);
endmodule

// File: tb/nmi_resume_regs_test.sv
module nmi_resume_regs_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic csr_we = 0;
  logic [31:0] csr_rdata;
  logic nmi_take = 0;
  logic [31:0] nmi_pc = '0;
  logic nmi_is_irq = 0;
  logic [5:0] nmi_code = '0;
  logic [1:0] cur_priv = 2'b11;
  logic insn_valid = 0;
  logic [31:0] insn = '0;
  logic ret_valid, clear_mprv, illegal_insn, nmi_enable;
  logic [31:0] ret_pc;
  logic [1:0] ret_priv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  nmi_resume_regs uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .nmi_take(nmi_take), .nmi_pc(nmi_pc),
    .nmi_is_irq(nmi_is_irq), .nmi_code(nmi_code), .cur_priv(cur_priv),
    .insn_valid(insn_valid), .insn(insn), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_priv(ret_priv), .clear_mprv(clear_mprv), .illegal_insn(illegal_insn),
    .nmi_enable(nmi_enable)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic csr_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    csr_addr = a;
    #1;
    check(req, csr_rdata, exp);
  endtask

  task automatic enter(input logic [31:0] pc, input logic irq, input logic [5:0] code,
                       input logic [1:0] priv);
    @(negedge clk);
    nmi_take = 1; nmi_pc = pc; nmi_is_irq = irq; nmi_code = code; cur_priv = priv;
    @(negedge clk);
    nmi_take = 0; cur_priv = 2'b11;
  endtask

  task automatic t_reset;
    csr_check("R1 scratch", 12'h740, 32'h0);
    csr_check("R1 epc", 12'h741, 32'h0);
    csr_check("R1 cause", 12'h742, 32'h0);
    csr_check("R1 status", 12'h744, 32'h0);
    check("R1 ret_valid", {31'b0, ret_valid}, 32'h0);
  endtask

  task automatic t_scratch;
    csr_write(12'h740, 32'hDEADBEEF);
    csr_check("R12 scratch", 12'h740, 32'hDEADBEEF);
    csr_write(12'h743, 32'hFFFFFFFF);
    csr_check("R12 hole 743", 12'h743, 32'h0);
    csr_check("R12 hole 745", 12'h745, 32'h0);
  endtask

  task automatic t_fields;
    csr_write(12'h741, 32'h12345677);
    csr_check("R8 epc bit0", 12'h741, 32'h12345676);
    csr_write(12'h742, 32'hFFFFFFFF);
    csr_check("R3 cause mask", 12'h742, 32'h8000003F);
    csr_write(12'h744, 32'hFFFFFFFF);
    csr_check("R4 status mask", 12'h744, 32'h00001808);
    csr_write(12'h744, 32'h00000808);
    csr_check("R5 pp 01 to M", 12'h744, 32'h00001808);
    csr_write(12'h744, 32'h00001000);
    csr_check("R5 pp 10 to M", 12'h744, 32'h00001800);
    csr_write(12'h744, 32'h00000000);
    csr_check("R5 pp 00 kept", 12'h744, 32'h00000000);
  endtask

  task automatic t_entry_user;
    csr_write(12'h744, 32'h00000008);
    check("R4 enable set", {31'b0, nmi_enable}, 32'h1);
    enter(32'h80001234, 1'b1, 6'd3, 2'b00);
    csr_check("R2 epc capture", 12'h741, 32'h80001234);
    csr_check("R3 cause capture", 12'h742, 32'h80000003);
    csr_check("R6 R4 status after entry", 12'h744, 32'h00000000);
    check("R4 enable cleared", {31'b0, nmi_enable}, 32'h0);
  endtask

  task automatic t_return_user_target;
    @(negedge clk);
    insn_valid = 1; insn = 32'h70200073; cur_priv = 2'b00;
    #1;
    check("R7 illegal in U", {31'b0, illegal_insn}, 32'h1);
    check("R7 no ret in U", {31'b0, ret_valid}, 32'h0);
    @(negedge clk);
    cur_priv = 2'b11;
    #1;
    check("R7 ret valid in M", {31'b0, ret_valid}, 32'h1);
    check("R7 legal in M", {31'b0, illegal_insn}, 32'h0);
    check("R2 ret_pc", ret_pc, 32'h80001234);
    check("R9 ret_priv U", {30'b0, ret_priv}, 32'h0);
    check("R9 clear_mprv", {31'b0, clear_mprv}, 32'h1);
    @(negedge clk);
    insn_valid = 0;
    #1;
    check("R10 enable after return", {31'b0, nmi_enable}, 32'h1);
  endtask

  task automatic t_return_machine_target;
    enter(32'h00000400, 1'b0, 6'd0, 2'b11);
    csr_check("R6 pp M", 12'h744, 32'h00001800);
    @(negedge clk);
    insn_valid = 1; insn = 32'h30200073;
    #1;
    check("R7 other insn no ret", {31'b0, ret_valid}, 32'h0);
    check("R7 other insn legal", {31'b0, illegal_insn}, 32'h0);
    insn = 32'h70200073;
    #1;
    check("R9 ret_priv M", {30'b0, ret_priv}, 32'h3);
    check("R9 no clear_mprv", {31'b0, clear_mprv}, 32'h0);
    check("R2 ret_pc M", ret_pc, 32'h00000400);
    @(negedge clk);
    insn_valid = 0;
  endtask

  task automatic t_priority;
    @(negedge clk);
    nmi_take = 1; nmi_pc = 32'hAAAA0010; nmi_is_irq = 1; nmi_code = 6'd5; cur_priv = 2'b00;
    csr_we = 1; csr_addr = 12'h741; csr_wdata = 32'h55550000;
    @(negedge clk);
    csr_addr = 12'h744; csr_wdata = 32'h00001808; cur_priv = 2'b11; nmi_pc = 32'hAAAA0020;
    @(negedge clk);
    nmi_take = 0; csr_we = 0;
    csr_check("R11 epc entry wins", 12'h741, 32'hAAAA0020);
    csr_check("R11 status entry wins", 12'h744, 32'h00001800);
    csr_check("R11 cause entry", 12'h742, 32'h80000005);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_scratch();
    t_fields();
    t_entry_user();
    t_return_user_target();
    t_return_machine_target();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule